// File: doc/BRIEF.md
# Bus Transceiver Mode Controller

This block is the state keeper of a single-wire vehicle bus transceiver. It holds one of three operating states (Normal, Sleep, Fail-safe) and from that state decides whether the external regulator is enabled, whether the bus termination is connected, whether the transmit path may drive the bus, what the receive output shows, and whether the transmit pin is pulled hard low.

The host controls the block through two pins. The enable pin selects the operating state, and the transmit pin decides whether a request to sleep is honoured. Both pins are brought into the clock domain by a two-stage synchroniser. The enable level then passes a debounce filter that counts microsecond ticks, with a separate hold time for each direction. The supply monitor supplies an "above 5 V" flag. Separate detectors, outside this block, supply one-cycle wake pulses for a bus wake and for a local wake.

After a wake, the block tells the host two things. It drives the receive output low to show that a wake occurred. It applies a strong pull-down on the transmit pin only when the wake was local, so the host can tell the wake source by reading that pin through its own pull-up. Both flags clear as soon as the filtered enable level is high.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: After reset the block is in Fail-safe with termination on, transmit path off, receive override active at level high, and the transmit strong pull-down off.
- R2: In Fail-safe, `inh_on` equals `supply_ok`. In Normal it is 1 and in Sleep it is 0.
- R3: In Fail-safe, a filtered enable level of 1 together with `supply_ok`=1 moves the block to Normal. Normal gives `tx_path_en`=1, `inh_on`=1, `term_on`=1 and `rx_ovr_en`=0. When `supply_ok` is 0, Normal is not entered.
- R4: In Normal, a filtered falling edge of enable moves the block to Sleep only if the synchronised transmit pin is 1 at that moment. If the pin is 0, the block stays in Normal.
- R5: Sleep gives `inh_on`=0, `term_on`=0, `tx_path_en`=0 and `rx_ovr_en`=1 with `rx_ovr_lvl`=1.
- R6: A `bus_wake` or `local_wake` pulse in Sleep moves the block to Fail-safe on the next clock edge and sets the wake request, seen as `rx_ovr_lvl`=0.
- R7: `txd_strong_pd` is 1 in Fail-safe only after a local wake. After a bus wake it stays 0. When both pulses arrive together, the local wake wins.
- R8: A filtered enable level of 1 clears the wake request and the wake source flag together. After this, `rx_ovr_lvl` and `txd_strong_pd` return to their idle values.
- R9: In Normal, `supply_ok`=0 moves the block to Fail-safe on the next clock edge, which turns off the transmit path.
- R10: An enable change takes effect only after it has held for `RISE_US` ticks (default 4) when rising, or `FALL_US` ticks (default 10) when falling. A shorter pulse has no effect.
- R11: In Fail-safe, a filtered falling edge of enable moves the block to Sleep whatever the transmit pin or supply level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| en_pin | input | 1 | Enable pin level, asynchronous |
| txd_pin | input | 1 | Transmit pin level, asynchronous |
| supply_ok | input | 1 | Supply above the 5 V threshold |
| bus_wake | input | 1 | One-cycle pulse: wake seen on the bus |
| local_wake | input | 1 | One-cycle pulse: wake seen on the local wake input |
| inh_on | output | 1 | Enable of the inhibit high-side switch |
| term_on | output | 1 | Bus termination pull-up connected |
| tx_path_en | output | 1 | Transmit path allowed to drive the bus |
| rx_ovr_en | output | 1 | Receive output replaced by `rx_ovr_lvl` |
| rx_ovr_lvl | output | 1 | Level shown on the receive output when overridden |
| txd_strong_pd | output | 1 | Strong pull-down on the transmit pin (local wake source) |

## Verification
The enable pin is driven with clean steps in both directions, with a low glitch shorter than the sleep filter, and with steps probed one tick short of each filter limit. These patterns separate a correct debounce from one that uses the wrong count, the wrong direction or no filter at all. Sleep requests are made with the transmit pin both low and high, which shows whether the qualification is present. Bus wakes and local wakes are sent one at a time from Sleep, and each is followed by an enable rise to clear the flags, which confirms that the two wake sources are reported differently. The supply flag is dropped in Fail-safe and again in Normal. This separates the inhibit-follows-supply behaviour from the forced drop out of Normal, and it sets up the falling-edge path from Fail-safe to Sleep.

// File: rtl/xcvr_mode_pkg.sv
// Shared types for the transceiver mode controller.
package xcvr_mode_pkg;

    // Operating state of the transceiver
    typedef enum logic [1:0] {
        MODE_FAILSAFE = 2'd0,
        MODE_NORMAL   = 2'd1,
        MODE_SLEEP    = 2'd2
    } mode_e;

endpackage

// File: rtl/xcvr_sync.sv
// Multi-stage synchroniser for one asynchronous pin level.
// Assumes: the pin changes slowly compared with clk.
module xcvr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] shreg;

    // Shift the pin level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= {STAGES{RST_VAL}};
        else        shreg <= {shreg[STAGES-2:0], din};
    end

    assign dout = shreg[STAGES-1];
endmodule

// File: rtl/xcvr_en_filter.sv
// Debounce filter for the synchronised enable level. A change is
// accepted once the new level has been seen on RISE_US (rising) or
// FALL_US (falling) consecutive microsecond ticks. It outputs the
// filtered level and one-cycle edge pulses.
// Assumes: din is already synchronised and us_tick is one cycle wide.
module xcvr_en_filter #(
    parameter int RISE_US = 4,
    parameter int FALL_US = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    localparam int MAX_US = (RISE_US > FALL_US) ? RISE_US : FALL_US;
    localparam int CW     = $clog2(MAX_US + 1);
    localparam logic [CW-1:0] RISE_LAST = CW'(RISE_US - 1);
    localparam logic [CW-1:0] FALL_LAST = CW'(FALL_US - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    // Pick the hold limit for the direction now pending
    always_comb last = din ? RISE_LAST : FALL_LAST;

    // Count ticks while the input differs from the accepted level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl  <= 1'b0;
            cnt  <= '0;
            rise <= 1'b0;
            fall <= 1'b0;
        end else begin
            rise <= 1'b0;
            fall <= 1'b0;
            if (din == lvl) begin
                cnt <= '0;
            end else if (us_tick) begin
                if (cnt == last) begin
                    lvl  <= din;
                    cnt  <= '0;
                    rise <= din;
                    fall <= ~din;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/xcvr_mode_fsm.sv
// Three-state mode machine with the wake-request and wake-source flags,
// and the output decode for each state.
// Assumes: enable inputs come from the debounce filter, txd_s is
// synchronised, and wake pulses are one cycle wide.
module xcvr_mode_fsm
    import xcvr_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_lvl,
    input  logic en_fall,
    input  logic txd_s,
    input  logic supply_ok,
    input  logic bus_wake,
    input  logic local_wake,
    output logic inh_on,
    output logic term_on,
    output logic tx_path_en,
    output logic rx_ovr_en,
    output logic rx_ovr_lvl,
    output logic txd_strong_pd
);
    mode_e mode;
    logic  wake_req;
    logic  src_local;

    // State transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_FAILSAFE;
        end else begin
            unique case (mode)
                MODE_FAILSAFE: begin
                    if (en_lvl && supply_ok) mode <= MODE_NORMAL;
                    else if (en_fall)        mode <= MODE_SLEEP;
                end
                MODE_NORMAL: begin
                    if (!supply_ok)           mode <= MODE_FAILSAFE;
                    else if (en_fall && txd_s) mode <= MODE_SLEEP;
                end
                MODE_SLEEP: begin
                    if (bus_wake || local_wake) mode <= MODE_FAILSAFE;
                end
                default: mode <= MODE_FAILSAFE;
            endcase
        end
    end

    // Wake request and wake source flags; enable high clears both
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_req  <= 1'b0;
            src_local <= 1'b0;
        end else if (en_lvl) begin
            wake_req  <= 1'b0;
            src_local <= 1'b0;
        end else if (mode == MODE_SLEEP && (bus_wake || local_wake)) begin
            wake_req  <= 1'b1;
            src_local <= local_wake;
        end
    end

    // Decode the pin controls from the state and the flags
    always_comb begin
        inh_on        = (mode == MODE_NORMAL) || (mode == MODE_FAILSAFE && supply_ok);
        term_on       = (mode != MODE_SLEEP);
        tx_path_en    = (mode == MODE_NORMAL);
        rx_ovr_en     = (mode != MODE_NORMAL);
        rx_ovr_lvl    = !(wake_req && mode == MODE_FAILSAFE);
        txd_strong_pd = src_local && (mode == MODE_FAILSAFE);
    end
endmodule

// File: rtl/xcvr_mode_ctrl.sv
// Top of the transceiver mode controller: synchronises the enable and
// transmit pins, debounces enable, and runs the mode machine.
// Assumes: rst_n is released once the supply first passes the
// power-up threshold; us_tick is a one-cycle pulse each microsecond.
module xcvr_mode_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int RISE_US     = 4,
    parameter int FALL_US     = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic en_pin,
    input  logic txd_pin,
    input  logic supply_ok,
    input  logic bus_wake,
    input  logic local_wake,
    output logic inh_on,
    output logic term_on,
    output logic tx_path_en,
    output logic rx_ovr_en,
    output logic rx_ovr_lvl,
    output logic txd_strong_pd
);
    logic en_s, txd_s;
    logic en_lvl, en_rise, en_fall;

    xcvr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_en_sync (
        .clk(clk), .rst_n(rst_n), .din(en_pin), .dout(en_s)
    );

    xcvr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_txd_sync (
        .clk(clk), .rst_n(rst_n), .din(txd_pin), .dout(txd_s)
    );

    xcvr_en_filter #(.RISE_US(RISE_US), .FALL_US(FALL_US)) u_en_filt (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .din(en_s),
        .lvl(en_lvl), .rise(en_rise), .fall(en_fall)
    );

    xcvr_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .en_lvl(en_lvl), .en_fall(en_fall),
        .txd_s(txd_s), .supply_ok(supply_ok), .bus_wake(bus_wake),
        .local_wake(local_wake), .inh_on(inh_on), .term_on(term_on),
        .tx_path_en(tx_path_en), .rx_ovr_en(rx_ovr_en),
        .rx_ovr_lvl(rx_ovr_lvl), .txd_strong_pd(txd_strong_pd)
    );

    logic unused_rise;
    assign unused_rise = en_rise;
endmodule

// File: rtl/xcvr_mode_ctrl_chk.sv
// Checker for the mode controller. It observes only the ports and is
// bound to every instance of the top module.
module xcvr_mode_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic bus_wake,
    input logic local_wake,
    input logic inh_on,
    input logic term_on,
    input logic tx_path_en,
    input logic rx_ovr_en,
    input logic rx_ovr_lvl,
    input logic txd_strong_pd
);
    // R5
    sleep_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !term_on |-> (!inh_on && !tx_path_en && rx_ovr_en && rx_ovr_lvl));

    // R3
    normal_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_path_en |-> (inh_on && term_on && !rx_ovr_en && !txd_strong_pd));

    // R2
    failsafe_inh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (term_on && !tx_path_en) |-> (inh_on == supply_ok));

    // R9
    undervolt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_path_en && !supply_ok) |=> !tx_path_en);

    // R6
    wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!term_on && (bus_wake || local_wake)) |=> (term_on && !rx_ovr_lvl));

    // R7
    local_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!term_on && local_wake) |=> txd_strong_pd);

    // R7
    pd_only_failsafe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txd_strong_pd |-> (term_on && !tx_path_en && !rx_ovr_lvl));

    // R4
    sleep_to_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !term_on |=> !tx_path_en);
endmodule

bind xcvr_mode_ctrl xcvr_mode_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .bus_wake(bus_wake),
    .local_wake(local_wake), .inh_on(inh_on), .term_on(term_on),
    .tx_path_en(tx_path_en), .rx_ovr_en(rx_ovr_en), .rx_ovr_lvl(rx_ovr_lvl),
    .txd_strong_pd(txd_strong_pd)
);

// File: tb/xcvr_mode_ctrl_bench.sv
// Directed bench for the transceiver mode controller.
module xcvr_mode_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int RISE_US    = 4;
    localparam int FALL_US    = 10;

    // Expected output vectors {inh, term, tx, ovr_en, ovr_lvl, strong_pd}
    localparam logic [5:0] V_FS       = 6'b110110;
    localparam logic [5:0] V_FS_LOWV  = 6'b010110;
    localparam logic [5:0] V_NORMAL   = 6'b111010;
    localparam logic [5:0] V_SLEEP    = 6'b000110;
    localparam logic [5:0] V_FS_BUSW  = 6'b110100;
    localparam logic [5:0] V_FS_LOCW  = 6'b110101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b0;
    logic en_pin = 1'b0;
    logic txd_pin = 1'b1;
    logic supply_ok = 1'b1;
    logic bus_wake = 1'b0;
    logic local_wake = 1'b0;
    logic inh_on, term_on, tx_path_en, rx_ovr_en, rx_ovr_lvl, txd_strong_pd;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    xcvr_mode_ctrl #(.RISE_US(RISE_US), .FALL_US(FALL_US)) u_xcvr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .en_pin(en_pin),
        .txd_pin(txd_pin), .supply_ok(supply_ok), .bus_wake(bus_wake),
        .local_wake(local_wake), .inh_on(inh_on), .term_on(term_on),
        .tx_path_en(tx_path_en), .rx_ovr_en(rx_ovr_en),
        .rx_ovr_lvl(rx_ovr_lvl), .txd_strong_pd(txd_strong_pd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Microsecond tick generator, driven away from the active edge
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            cnt = (cnt + 1) % TICK_DIV;
            us_tick = (cnt == 0);
        end
    end

    task automatic wait_clks(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [5:0] exp);
        logic [5:0] act;
        act = {inh_on, term_on, tx_path_en, rx_ovr_en, rx_ovr_lvl, txd_strong_pd};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs %b expected %b", req, act, exp);
        end
    endtask

    task automatic pulse_wake(input bit local_src);
        if (local_src) local_wake = 1'b1; else bus_wake = 1'b1;
        @(negedge clk);
        local_wake = 1'b0;
        bus_wake   = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        wait_clks(3);
        rst_n = 1'b1;
        wait_clks(1);
        check("R1 reset state", V_FS);
    endtask

    task automatic t_supply_failsafe();
        supply_ok = 1'b0;
        wait_clks(2);
        check("R2 inhibit follows supply", V_FS_LOWV);
        en_pin = 1'b1;
        wait_clks(60);
        check("R3 no Normal while under-voltage", V_FS_LOWV);
        supply_ok = 1'b1;
        wait_clks(3);
        check("R3 Normal entered", V_NORMAL);
    endtask

    task automatic t_glitch();
        en_pin = 1'b0;
        wait_clks(2 * TICK_DIV);
        en_pin = 1'b1;
        wait_clks(80);
        check("R10 short low pulse ignored", V_NORMAL);
    endtask

    task automatic t_txd_low_qual();
        txd_pin = 1'b0;
        en_pin  = 1'b0;
        wait_clks(80);
        check("R4 sleep refused with transmit low", V_NORMAL);
        en_pin = 1'b1;
        wait_clks(60);
        txd_pin = 1'b1;
        wait_clks(4);
    endtask

    task automatic t_sleep_filter();
        en_pin = 1'b0;
        wait_clks((FALL_US - 1) * TICK_DIV);
        check("R10 fall filter not yet expired", V_NORMAL);
        wait_clks(30);
        check("R4 R5 Sleep entered", V_SLEEP);
    endtask

    task automatic t_wake(input bit local_src);
        pulse_wake(local_src);
        wait_clks(1);
        if (local_src) check("R6 R7 local wake report", V_FS_LOCW);
        else           check("R6 R7 bus wake report", V_FS_BUSW);
    endtask

    task automatic t_rise_filter_clear(input logic [5:0] pending);
        en_pin = 1'b1;
        wait_clks((RISE_US - 1) * TICK_DIV);
        check("R10 rise filter not yet expired", pending);
        wait_clks(30);
        check("R8 R3 flags cleared in Normal", V_NORMAL);
    endtask

    task automatic t_uv_and_fs_sleep();
        supply_ok = 1'b0;
        wait_clks(2);
        check("R9 under-voltage leaves Normal", V_FS_LOWV);
        en_pin = 1'b0;
        wait_clks(80);
        check("R11 enable fall in Fail-safe sleeps", V_SLEEP);
        supply_ok = 1'b1;
        wait_clks(2);
        check("R5 Sleep holds after supply returns", V_SLEEP);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_supply_failsafe();
        t_glitch();
        t_txd_low_qual();
        t_sleep_filter();
        t_wake(1'b0);
        t_rise_filter_clear(V_FS_BUSW);
        t_sleep_filter();
        t_wake(1'b1);
        t_rise_filter_clear(V_FS_LOCW);
        t_uv_and_fs_sleep();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule